// File: doc/BRIEF.md
# Read-While-Write Conflict Responder

This block sits in front of a multi-bank non-volatile memory and decides what happens when a read arrives for a bank that is in the middle of a long program or erase operation. Reads to idle banks are granted in the same cycle they are requested. A read that hits a busy bank is held off until the bank can serve it. Configuration inputs choose the reaction. It can be a plain stall, a stall that raises a sticky notification flag, or an abort of the running operation so the read can go sooner. The abort can raise its own sticky flag.

The program/erase sequencer is outside this block. Each bank is seen only through a busy level, a one-cycle done pulse and an abort request that this block drives. The requester holds `rd_req` and `rd_bank` steady until it sees `rd_grant`. If it drops `rd_req` while stalled, the stall is cancelled.

Top module: `rww_ctrl`

## Requirements
- R1: When no read is stalled and `rd_req` targets a bank whose `bank_busy` bit is 0, `rd_grant` is 1 in that same cycle and `rd_stall` is 0.
- R2: When no read is stalled and `rd_req` targets a bank whose `bank_busy` bit is 1, `rd_grant` is 0 and `rd_stall` is 1. The read then stays stalled, with `rd_stall` high, until it is released or cancelled.
- R3: The release rule is chosen by the value `cfg_abort_en` had when the stall began. If it was 1, the stalled read is granted in the first cycle the held bank's `bank_busy` bit is 0. If it was 0, the read is granted only in a cycle where the held bank's `op_done` bit is 1.
- R4: If `cfg_abort_en` is 1 when a stall begins, `op_abort` has only bit number `rd_bank` set in the next cycle, for exactly one cycle. At all other times `op_abort` is 0.
- R5: If `cfg_stall_irq_en` is 1 when a stall begins, `irq_stall` is 1 from the next cycle on.
- R6: If both `cfg_abort_en` and `cfg_abort_irq_en` are 1 when a stall begins, `irq_abort` is 1 from the next cycle on.
- R7: Both flags are sticky. `irq_clr[0]` clears `irq_stall` and `irq_clr[1]` clears `irq_abort`, each in the next cycle. A new set event in the same cycle wins over the clear.
- R8: With all three configuration inputs at 0, a conflict produces a plain stall released by `op_done`, with no abort and no flag.
- R9: Dropping `rd_req` while stalled ends the stall. The next request is judged afresh as under R1 or R2.
- R10: After reset, `op_abort`, `irq_stall` and `irq_abort` are 0 and no read is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_stall_irq_en | input | 1 | Raise stall flag on conflict |
| cfg_abort_en | input | 1 | Abort the bank operation on conflict |
| cfg_abort_irq_en | input | 1 | Raise abort flag when aborting |
| rd_req | input | 1 | Read request, held until granted |
| rd_bank | input | BANK_W | Target bank of the read |
| bank_busy | input | NUM_BANKS | Per-bank program/erase busy level |
| op_done | input | NUM_BANKS | Per-bank operation-complete pulse |
| irq_clr | input | 2 | Write-one-to-clear: bit 0 stall flag, bit 1 abort flag |
| rd_grant | output | 1 | Read may proceed this cycle |
| rd_stall | output | 1 | Read is pending and held off |
| op_abort | output | NUM_BANKS | One-cycle abort request per bank |
| irq_stall | output | 1 | Sticky stall notification |
| irq_abort | output | 1 | Sticky abort notification |

## Verification
Random traffic mixes reads to idle and busy banks while the busy and done pulses toggle freely on all banks. This shows whether the release follows the held bank or wrongly follows the bank currently addressed. Configuration sets are swapped during stalls, which shows whether the release rule and the abort come from the settings latched when the stall began. Directed sequences cover a done pulse on a different bank, a clear that coincides with a new set, and a cancelled stall followed at once by a fresh request.

// File: rtl/rww_pkg.sv
package rww_pkg;
  typedef enum logic {
    RWW_IDLE = 1'b0,
    RWW_HOLD = 1'b1
  } rww_state_e;

  localparam int RWW_NUM_FLAGS = 2;
  localparam int RWW_FLAG_STALL = 0;
  localparam int RWW_FLAG_ABORT = 1;
endpackage

// File: rtl/rww_conflict_fsm.sv
module rww_conflict_fsm
  import rww_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_abort_en,
  input  logic                 rd_req,
  input  logic [BANK_W-1:0]    rd_bank,
  input  logic [NUM_BANKS-1:0] bank_busy,
  input  logic [NUM_BANKS-1:0] op_done,
  output logic                 rd_grant,
  output logic                 rd_stall,
  output logic                 stall_start,
  output logic                 hold_st,
  output logic                 hold_mode,
  output logic [BANK_W-1:0]    hold_bank,
  output logic [NUM_BANKS-1:0] op_abort
);
  localparam logic [NUM_BANKS-1:0] ONE = {{(NUM_BANKS-1){1'b0}}, 1'b1};

  rww_state_e            state_q, state_d;
  logic [BANK_W-1:0]     bank_q;
  logic                  mode_q;
  logic                  capture_en;
  logic [NUM_BANKS-1:0]  abort_q, abort_d;
  logic [NUM_BANKS-1:0]  req_mask, held_mask;
  logic                  req_busy, held_busy, held_done;

  assign req_mask  = ONE << rd_bank;
  assign held_mask = ONE << bank_q;
  assign req_busy  = |(bank_busy & req_mask);
  assign held_busy = |(bank_busy & held_mask);
  assign held_done = |(op_done & held_mask);

  always_comb begin
    state_d     = state_q;
    capture_en  = 1'b0;
    rd_grant    = 1'b0;
    stall_start = 1'b0;
    case (state_q)
      RWW_IDLE: begin
        if (rd_req) begin
          if (req_busy) begin
            stall_start = 1'b1;
            capture_en  = 1'b1;
            state_d     = RWW_HOLD;
          end else begin
            rd_grant = 1'b1;
          end
        end
      end
      RWW_HOLD: begin
        if (!rd_req) begin
          state_d = RWW_IDLE;
        end else if (mode_q ? !held_busy : held_done) begin
          rd_grant = 1'b1;
          state_d  = RWW_IDLE;
        end
      end
      default: state_d = RWW_IDLE;
    endcase
    abort_d = (stall_start && cfg_abort_en) ? req_mask : '0;
  end

  assign rd_stall = rd_req & ~rd_grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RWW_IDLE;
      abort_q <= '0;
    end else begin
      state_q <= state_d;
      abort_q <= abort_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      mode_q <= 1'b0;
    end else if (capture_en) begin
      bank_q <= rd_bank;
      mode_q <= cfg_abort_en;
    end
  end

  assign hold_st   = (state_q == RWW_HOLD);
  assign hold_mode = mode_q;
  assign hold_bank = bank_q;
  assign op_abort  = abort_q;
endmodule

// File: rtl/rww_sticky_flag.sv
module rww_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rww_ctrl.sv
module rww_ctrl
  import rww_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_stall_irq_en,
  input  logic                     cfg_abort_en,
  input  logic                     cfg_abort_irq_en,
  input  logic                     rd_req,
  input  logic [BANK_W-1:0]        rd_bank,
  input  logic [NUM_BANKS-1:0]     bank_busy,
  input  logic [NUM_BANKS-1:0]     op_done,
  input  logic [RWW_NUM_FLAGS-1:0] irq_clr,
  output logic                     rd_grant,
  output logic                     rd_stall,
  output logic [NUM_BANKS-1:0]     op_abort,
  output logic                     irq_stall,
  output logic                     irq_abort
);
  logic                     stall_start;
  logic                     hold_st;
  logic                     hold_mode;
  logic [BANK_W-1:0]        hold_bank;
  logic [RWW_NUM_FLAGS-1:0] flag_set;
  logic [RWW_NUM_FLAGS-1:0] flag_q;

  rww_conflict_fsm #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_abort_en(cfg_abort_en),
    .rd_req      (rd_req),
    .rd_bank     (rd_bank),
    .bank_busy   (bank_busy),
    .op_done     (op_done),
    .rd_grant    (rd_grant),
    .rd_stall    (rd_stall),
    .stall_start (stall_start),
    .hold_st     (hold_st),
    .hold_mode   (hold_mode),
    .hold_bank   (hold_bank),
    .op_abort    (op_abort)
  );

  assign flag_set[RWW_FLAG_STALL] = stall_start & cfg_stall_irq_en;
  assign flag_set[RWW_FLAG_ABORT] = stall_start & cfg_abort_en & cfg_abort_irq_en;

  for (genvar g = 0; g < RWW_NUM_FLAGS; g++) begin : g_flag
    rww_sticky_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flag_set[g]),
      .clr_i (irq_clr[g]),
      .flag_o(flag_q[g])
    );
  end

  assign irq_stall = flag_q[RWW_FLAG_STALL];
  assign irq_abort = flag_q[RWW_FLAG_ABORT];
endmodule

// File: rtl/rww_ctrl_chk.sv
module rww_ctrl_chk #(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_stall_irq_en,
  input logic                 rd_req,
  input logic [BANK_W-1:0]    rd_bank,
  input logic [NUM_BANKS-1:0] bank_busy,
  input logic [NUM_BANKS-1:0] op_done,
  input logic [1:0]           irq_clr,
  input logic                 rd_grant,
  input logic                 rd_stall,
  input logic [NUM_BANKS-1:0] op_abort,
  input logic                 irq_stall,
  input logic                 irq_abort,
  input logic                 hold_st,
  input logic                 hold_mode,
  input logic [BANK_W-1:0]    hold_bank
);
  localparam logic [NUM_BANKS-1:0] ONE = {{(NUM_BANKS-1){1'b0}}, 1'b1};

  logic req_busy, held_done;
  assign req_busy  = |(bank_busy & (ONE << rd_bank));
  assign held_done = |(op_done & (ONE << hold_bank));

  assert_idle_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_st && rd_req && !req_busy) |-> (rd_grant && !rd_stall));

  assert_conflict_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_st && rd_req && req_busy) |-> (rd_stall && !rd_grant));

  assert_wait_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_st && !hold_mode && !held_done) |-> !rd_grant);

  assert_abort_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(op_abort));

  assert_abort_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_abort != '0) |=> (op_abort == '0));

  assert_abort_in_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_abort != '0) |-> (hold_st && hold_mode));

  assert_stall_flag_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_stall) |-> ($past(rd_stall) && $past(cfg_stall_irq_en)));

  assert_abort_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_abort) |-> (op_abort != '0));

  assert_stall_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stall && !irq_clr[0]) |=> irq_stall);

  assert_abort_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_abort && !irq_clr[1]) |=> irq_abort);
endmodule

bind rww_ctrl rww_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_W   (BANK_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_stall_irq_en(cfg_stall_irq_en),
  .rd_req          (rd_req),
  .rd_bank         (rd_bank),
  .bank_busy       (bank_busy),
  .op_done         (op_done),
  .irq_clr         (irq_clr),
  .rd_grant        (rd_grant),
  .rd_stall        (rd_stall),
  .op_abort        (op_abort),
  .irq_stall       (irq_stall),
  .irq_abort       (irq_abort),
  .hold_st         (hold_st),
  .hold_mode       (hold_mode),
  .hold_bank       (hold_bank)
);

// File: tb/rww_ctrl_tb.sv
`timescale 1ns/1ps
module rww_ctrl_tb;
  localparam int NB = 3;
  localparam int BW = 2;

  logic          clk, rst_n;
  logic          c_sirq, c_abt, c_airq;
  logic          rd_req;
  logic [BW-1:0] rd_bank;
  logic [NB-1:0] bank_busy, op_done, op_abort;
  logic [1:0]    irq_clr;
  logic          rd_grant, rd_stall, irq_stall, irq_abort;

  int checks = 0, fails = 0;

  logic          m_hold, m_mode, m_is, m_ia;
  logic [BW-1:0] m_bank;
  logic [NB-1:0] m_abort;

  rww_ctrl #(.NUM_BANKS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_stall_irq_en(c_sirq), .cfg_abort_en(c_abt),
    .cfg_abort_irq_en(c_airq), .rd_req(rd_req), .rd_bank(rd_bank),
    .bank_busy(bank_busy), .op_done(op_done), .irq_clr(irq_clr),
    .rd_grant(rd_grant), .rd_stall(rd_stall), .op_abort(op_abort),
    .irq_stall(irq_stall), .irq_abort(irq_abort)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic exp_grant();
    if (!rd_req) return 1'b0;
    if (!m_hold) return !bank_busy[rd_bank];
    return m_mode ? !bank_busy[m_bank] : op_done[m_bank];
  endfunction

  task automatic chk(input logic [NB-1:0] act, input logic [NB-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: inputs already driven after negedge
  task automatic cyc();
    logic g, st;
    #1;
    g = exp_grant();
    chk(NB'(rd_grant), NB'(g), m_hold ? "R3 grant after stall" : "R1 grant");
    chk(NB'(rd_stall), NB'(rd_req & !g), "R2 stall");
    chk(op_abort, m_abort, "R4 abort pulse");
    chk(NB'(irq_stall), NB'(m_is), "R5 stall flag");
    chk(NB'(irq_abort), NB'(m_ia), "R6 abort flag");
    st = !m_hold && rd_req && bank_busy[rd_bank];
    @(posedge clk);
    m_abort = (st && c_abt) ? (NB'(1) << rd_bank) : '0;
    m_is = (st && c_sirq) | (m_is & !irq_clr[0]);          // R7
    m_ia = (st && c_abt && c_airq) | (m_ia & !irq_clr[1]);
    if (st) begin m_hold = 1'b1; m_bank = rd_bank; m_mode = c_abt; end
    else if (m_hold && (!rd_req || g)) m_hold = 1'b0;          // R9
    @(negedge clk);
  endtask

  task automatic drv(input logic rq, input logic [BW-1:0] bk, input logic [NB-1:0] by,
                     input logic [NB-1:0] dn, input logic [1:0] cl);
    rd_req = rq; rd_bank = bk; bank_busy = by; op_done = dn; irq_clr = cl;
    cyc();
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; c_sirq = 0; c_abt = 0; c_airq = 0;
    rd_req = 0; rd_bank = 0; bank_busy = 0; op_done = 0; irq_clr = 0;
    m_hold = 0; m_mode = 0; m_is = 0; m_ia = 0; m_bank = 0; m_abort = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(op_abort, '0, "R10 abort at reset");
    chk(NB'({irq_stall, irq_abort}), '0, "R10 flags at reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R8: plain stall, done on a different bank must not release
    drv(1, 1, 3'b010, 0, 0);
    drv(1, 1, 3'b010, 3'b001, 0);
    drv(1, 1, 3'b000, 0, 0);
    drv(1, 1, 3'b000, 3'b010, 0);
    // R1: idle pass-through
    drv(1, 2, 3'b011, 0, 0);
    // R4/R6: abort with both flags
    c_sirq = 1; c_abt = 1; c_airq = 1;
    drv(1, 2, 3'b100, 0, 0);
    c_abt = 0;  // latched mode must still govern release (R3)
    drv(1, 2, 3'b100, 0, 0);
    drv(1, 2, 3'b000, 0, 0);
    // R7: clear vs new set in same cycle
    drv(1, 0, 3'b001, 0, 2'b11);
    drv(0, 0, 3'b001, 0, 2'b11);
    drv(0, 0, 0, 0, 0);
    // R9: cancel then fresh request to an idle bank
    drv(1, 1, 3'b010, 0, 0);
    drv(0, 1, 3'b010, 0, 0);
    drv(1, 1, 3'b000, 0, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic rq; logic [BW-1:0] bk;
      if (i % 64 == 0) begin
        c_sirq = $urandom_range(0, 1); c_abt = $urandom_range(0, 1); c_airq = $urandom_range(0, 1);
      end
      if (m_hold) begin rq = ($urandom_range(0, 15) != 0); bk = m_bank; end
      else begin rq = $urandom_range(0, 1); bk = BW'($urandom_range(0, NB-1)); end
      drv(rq, bk, NB'($urandom), NB'($urandom) & NB'($urandom),
          ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule